// File: doc/BRIEF.md
# Vector Block Header Parcel Parser

This block watches a stream of 16-bit instruction parcels while it searches for the header of a vector block. It takes a parcel as a header when the low seven bits are all ones. The header then carries a two-bit mode that says how many more parcels belong to the block preamble. There can be none, one short prefix, a short prefix plus the upper half of a long prefix, or those two plus a second short prefix. The parser captures each of those parcels into a registered field. Once the preamble is complete it raises `done` and holds it. The parcel that arrives next is therefore the first instruction of the block.

The consumer downstream reads the captured fields while `done` is high and acknowledges with `done_ack`. Mode zero selects an extended header layout that this block does not decode. For that mode the parser only raises `ext_fmt` and completes at once. Reserved bits that are set are reported on a sticky error output, and parsing continues as normal. A flush drops any parse in progress and clears every captured value.

Top module: `vblk_hdr_parser`

## Requirements
- R1: While searching, an accepted parcel whose bits 6:0 are not 7'b1111111 is discarded and changes no output. An accepted parcel whose bits 6:0 equal 7'b1111111 starts a new preamble.
- R2: When a header is accepted, `mode` takes header bits 8:7 and `blk_len` takes header bits 14:12. The prefix fields return to zero at the same time.
- R3: With mode 2'b01, the one parcel after the header is captured: its bits 10:0 go to `short_pfx`, and `done` rises after that parcel.
- R4: With mode 2'b10, the second parcel after the header is captured whole into `long_pfx`, and `done` rises after it.
- R5: With mode 2'b11, a third parcel follows, and its bits 10:0 go to `second_pfx`. No field other than `second_pfx` takes this parcel.
- R6: With mode 2'b00, `done` rises in the cycle after the header and `ext_fmt` is 1. For any other mode, `ext_fmt` is 0 after the header.
- R7: A header with any of bits 15, 11, 10 or 9 set sets `rsv_err`. So does a short or second-short prefix parcel with any of bits 15:11 set. The flag stays set until reset or flush, and parsing carries on unchanged.
- R8: `done` stays high until a cycle in which `done_ack` is 1, and it is low in the following cycle. `in_ready` is 0 exactly when `done` is 1 and `done_ack` is 0.
- R9: A cycle with `flush` high returns the parser to the search state. In the next cycle every output field is zero, along with `done`, `ext_fmt` and `rsv_err`. A parcel accepted in the flush cycle has no effect.
- R10: A parcel accepted in the cycle where `done` is acknowledged is handled as a header-search parcel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Drop the current parse and clear all fields |
| in_valid | input | 1 | A parcel is offered |
| in_data | input | 16 | Parcel value |
| in_ready | output | 1 | The parser takes the offered parcel |
| done_ack | input | 1 | The consumer has taken the captured preamble |
| done | output | 1 | The preamble is complete; the next parcel is the first instruction |
| mode | output | 2 | Prefix mode from the header |
| blk_len | output | 3 | Length field from the header |
| short_pfx | output | 11 | First short prefix |
| long_pfx | output | 16 | Upper half of the long prefix |
| second_pfx | output | 11 | Second short prefix (twin mode) |
| ext_fmt | output | 1 | The header selected the extended, non-prefix layout |
| rsv_err | output | 1 | Sticky flag: a reserved bit was seen set |

## Verification
Every field, `done`, `ext_fmt` and `rsv_err` is registered. Each one is due on the clock edge that accepts the parcel responsible for it, so the bench compares them at the falling edge after that edge. `in_ready` is combinational from `done` and `done_ack`. The bench checks it in the same cycle, one time step after the inputs are driven. The bench's reference model takes the same accepted parcel on the same edge, so a cycle of lag in any output shows up as a mismatch.

// File: rtl/vblk_hdr_parser.sv
module vblk_hdr_parser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        in_valid,
  input  logic [15:0] in_data,
  output logic        in_ready,
  input  logic        done_ack,
  output logic        done,
  output logic [1:0]  mode,
  output logic [2:0]  blk_len,
  output logic [10:0] short_pfx,
  output logic [15:0] long_pfx,
  output logic [10:0] second_pfx,
  output logic        ext_fmt,
  output logic        rsv_err
);
  logic [1:0] need_q, idx_q;
  logic acc, searching, is_hdr;

  assign in_ready  = !(done && !done_ack);
  assign acc       = in_valid && in_ready;
  assign searching = need_q == 2'd0;
  assign is_hdr    = in_data[6:0] == 7'h7f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_q <= '0; idx_q <= '0; done <= 1'b0; mode <= '0; blk_len <= '0;
      short_pfx <= '0; long_pfx <= '0; second_pfx <= '0;
      ext_fmt <= 1'b0; rsv_err <= 1'b0;
    end else if (flush) begin
      need_q <= '0; idx_q <= '0; done <= 1'b0; mode <= '0; blk_len <= '0;
      short_pfx <= '0; long_pfx <= '0; second_pfx <= '0;
      ext_fmt <= 1'b0; rsv_err <= 1'b0;
    end else begin
      if (done && done_ack) done <= 1'b0;
      if (acc && searching && is_hdr) begin
        mode       <= in_data[8:7];
        blk_len    <= in_data[14:12];
        short_pfx  <= '0;
        long_pfx   <= '0;
        second_pfx <= '0;
        ext_fmt    <= in_data[8:7] == 2'b00;
        need_q     <= in_data[8:7];
        idx_q      <= '0;
        done       <= in_data[8:7] == 2'b00;
        if (in_data[15] || |in_data[11:9]) rsv_err <= 1'b1;
      end else if (acc && !searching) begin
        case (idx_q)
          2'd0: begin
            short_pfx <= in_data[10:0];
            if (|in_data[15:11]) rsv_err <= 1'b1;
          end
          2'd1: long_pfx <= in_data;
          default: begin
            second_pfx <= in_data[10:0];
            if (|in_data[15:11]) rsv_err <= 1'b1;
          end
        endcase
        need_q <= need_q - 2'd1;
        idx_q  <= idx_q + 2'd1;
        if (need_q == 2'd1) done <= 1'b1;
      end
    end
  end

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || flush)
    done && !done_ack |=> done && $stable(short_pfx) && $stable(long_pfx) && $stable(second_pfx));
  assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n || flush)
    done && done_ack && !(in_valid && in_data[6:0] == 7'h7f && in_data[8:7] == 2'b00) |=> !done);
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !done && !rsv_err && !ext_fmt && mode == 2'b00 && short_pfx == '0 && long_pfx == '0);
  assert_rsv_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n || flush)
    rsv_err |=> rsv_err);
  assert_ext_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fmt |-> mode == 2'b00);
  assert_twin_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    second_pfx != '0 |-> mode == 2'b11);
  assert_done_cause_R3: assert property (@(posedge clk) disable iff (!rst_n || flush)
    $rose(done) |-> $past(in_valid));
endmodule

// File: tb/vblk_hdr_parser_bench.sv
module vblk_hdr_parser_bench;
  logic clk = 0, rst_n = 0, flush = 0, in_valid = 0, done_ack = 0;
  logic [15:0] in_data = 0;
  logic in_ready, done, ext_fmt, rsv_err;
  logic [1:0] mode; logic [2:0] blk_len;
  logic [10:0] short_pfx, second_pfx; logic [15:0] long_pfx;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  vblk_hdr_parser u_vblk_hdr_parser (.clk, .rst_n, .flush, .in_valid, .in_data, .in_ready,
    .done_ack, .done, .mode, .blk_len, .short_pfx, .long_pfx, .second_pfx, .ext_fmt, .rsv_err);

  int m_need, m_idx, m_mode, m_len, m_short, m_long, m_second;
  bit m_done, m_ext, m_rsv;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_clear();
    m_need = 0; m_idx = 0; m_mode = 0; m_len = 0; m_short = 0; m_long = 0;
    m_second = 0; m_done = 0; m_ext = 0; m_rsv = 0;
  endtask

  task automatic compare_regs();
    chk("R8 done", done, m_done);
    chk("R2 mode", mode, m_mode);
    chk("R2 blk_len", blk_len, m_len);
    chk("R3 short_pfx", short_pfx, m_short);
    chk("R4 long_pfx", long_pfx, m_long);
    chk("R5 second_pfx", second_pfx, m_second);
    chk("R6 ext_fmt", ext_fmt, m_ext);
    chk("R7 rsv_err", rsv_err, m_rsv);
  endtask

  // one clock: drive inputs, check, advance the model
  task automatic step(bit v, logic [15:0] d, bit a, bit f);
    bit rdy, taken;
    @(negedge clk);
    compare_regs();
    in_valid = v; in_data = d; done_ack = a; flush = f;
    #1;
    rdy = !(m_done && !a);
    chk("R8 in_ready", in_ready, rdy);
    taken = v && rdy;
    if (f) m_clear();
    else begin
      if (m_done && a) m_done = 0;
      if (taken && m_need == 0) begin
        if (d[6:0] == 7'h7f) begin
          m_mode = d[8:7]; m_len = d[14:12]; m_short = 0; m_long = 0; m_second = 0;
          m_ext = (m_mode == 0); m_need = m_mode; m_idx = 0; m_done = (m_mode == 0);
          if (d[15] || d[11:9] != 0) m_rsv = 1;
        end
      end else if (taken) begin
        if (m_idx == 0) begin m_short = d[10:0]; if (d[15:11] != 0) m_rsv = 1; end
        else if (m_idx == 1) m_long = d;
        else begin m_second = d[10:0]; if (d[15:11] != 0) m_rsv = 1; end
        m_idx++; m_need--;
        if (m_need == 0) m_done = 1;
      end
    end
  endtask

  function automatic logic [15:0] hdr(int md, int ln);
    return {1'b0, 3'(ln), 3'b000, 2'(md), 7'h7f};
  endfunction

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    compare_regs();                               // reset state
    rst_n = 1;
    step(1, 16'h1234, 0, 0);                      // R1 non-header discarded
    step(1, 16'h007e, 0, 0);
    step(0, 0, 0, 0);
    chk("R1 no block start", done, 0);
    step(1, hdr(1, 5), 0, 0);                     // R3 short mode
    step(1, 16'h07ab, 0, 0);
    step(1, 16'h1111, 0, 0);                      // held, R8
    step(1, 16'h1111, 0, 0);
    step(0, 0, 1, 0);
    step(1, hdr(2, 3), 0, 0);                     // R4 long mode
    step(0, 0, 0, 0);
    step(1, 16'h0155, 0, 0);
    step(1, 16'hbeef, 0, 0);
    step(0, 0, 1, 0);
    step(1, hdr(3, 7), 0, 0);                     // R5 twin mode
    step(1, 16'h0001, 0, 0);
    step(1, 16'hcafe, 0, 0);
    step(1, 16'h0402, 0, 0);
    step(0, 0, 0, 0);
    chk("R5 second_pfx", second_pfx, 11'h402);
    step(1, hdr(0, 2), 1, 0);                     // R10 header during ack, R6 ext
    step(0, 0, 0, 0);
    chk("R6 ext_fmt", ext_fmt, 1);
    chk("R10 done after ack-cycle header", done, 1);
    step(1, hdr(1, 0) | 16'h0200, 1, 0);          // R7 reserved header bit
    step(1, 16'hf800, 0, 0);
    step(1, hdr(2, 1), 1, 0);
    step(1, 16'h0003, 0, 0);
    step(1, 16'h0004, 0, 0);
    chk("R7 rsv_err sticky", rsv_err, 1);
    step(1, hdr(3, 1), 1, 1);                     // R9 flush wins over parcel
    step(0, 0, 0, 0);
    chk("R9 cleared", {done, rsv_err, mode}, 0);
    step(1, hdr(3, 4), 0, 0);
    step(1, 16'h0010, 0, 0);
    step(1, 16'h0020, 0, 1);                      // R9 mid-block flush
    step(1, 16'h0030, 0, 0);
    chk("R9 after mid flush", {done, short_pfx}, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if ($urandom_range(0, 2) == 0) d[6:0] = 7'h7f;
      if ($urandom_range(0, 3) != 0) d[15:11] = 0;
      step($urandom_range(0, 3) != 0, d, $urandom_range(0, 2) == 0, $urandom_range(0, 60) == 0);
    end
    @(negedge clk);
    compare_regs();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule